// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Clock Output

The block sends one word per frame on a serial data line. A frame is a low start bit, then eight or nine data bits with the least significant bit first, then a high stop bit. Every bit lasts a whole number of system clocks, set by a divisor. While the data bits go out, the block drives a serial clock. The clock rests at a selectable idle level and pulses once per data bit, in the first or the second half of the bit. An option removes the pulse on the final data bit.

On the mid-bit clock edge of each data bit, the block samples the receive input. The received word is assembled while the transmission runs. At the end of the frame it is presented together with a one-cycle strobe.

A single-wire mode loops the transmit line back into the receive path and turns off the serial clock. In this mode the transmit driver is enabled only while a frame is being sent. Configuration inputs are followed only while no frame is in progress.

Top module: `sync_serial_tx`

## Requirements
- R1: A word accepted while idle is sent as follows: a 0 start bit, then the data bits with bit 0 first, then a 1 stop bit. Each bit lasts D clocks, and `tx` rests at 1 when idle. With `cfg_nine`=1 the frame has nine data bits. With `cfg_nine`=0 it has eight, and `ld_data[8]` is ignored.
- R2: `busy` goes high in the clock after the load is accepted. It stays high for exactly (N+2)*D clocks, where N is the number of data bits.
- R3: Let c be the clock count within a data bit (0..D-1) and H = floor(D/2). `sclk` takes the level opposite to `cfg_cpol` in these cases: for c >= H when `cfg_cpha`=0, and for c < H when `cfg_cpha`=1.
- R4: With `cfg_lastclk`=0 the final data bit gets no `sclk` pulse. With `cfg_lastclk`=1 it gets one like every other data bit.
- R5: During idle, the start bit and the stop bit, `sclk` stays at the level of `cfg_cpol`. While idle, that level follows the input within two clocks.
- R6: `rx` is sampled at the clock where c becomes H in data bit i, and the result is stored as bit i of `rx_word`. When the frame ends, `rx_done` pulses for one clock in the clock where `busy` falls. In 8-bit frames, `rx_word[8]` is 0.
- R7: With `cfg_hdx`=1, several things change. `sclk` stays at its idle level for the whole frame. The receive path takes `tx` instead of `rx`. `rx_done` is not pulsed. `tx_oe` is 1 only while `busy`. With `cfg_hdx`=0, `tx_oe` is always 1.
- R8: A load request made while `busy` is ignored: no second frame follows. Configuration changes made during a frame do not alter that frame.
- R9: A divisor below 4 is treated as 4.
- R10: After reset, the outputs are as follows: `tx`=1, `tx_oe`=1, `sclk`=0, `busy`=0, `rx_done`=0 and `rx_word`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request for `ld_data` |
| ld_data | input | 9 | Word to send |
| cfg_nine | input | 1 | 1: nine data bits, 0: eight |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: pulse in second half of bit, 1: in first half |
| cfg_lastclk | input | 1 | 1: pulse on the final data bit |
| cfg_hdx | input | 1 | Single-wire mode |
| cfg_div | input | DIV_W | Bit period in clocks |
| rx | input | 1 | Serial receive data |
| tx | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit driver enable |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | Frame in progress |
| rx_word | output | 9 | Received word |
| rx_done | output | 1 | One-cycle strobe, received word valid |

## Verification
The frames sent cover all four combinations of clock polarity and phase, both word lengths, and the final-bit pulse both present and absent. They use several divisors, including one below the minimum. The receive input carries a pattern that differs from the transmitted data. This separates the capture path from the loopback path, and it exposes any swap of bit order or bit index.

One frame has a second load request and configuration flips injected mid-frame. It exposes any path by which a frame accepts changes while busy. A single-wire frame, followed by idle checks, separates the driver-enable and clock-gating rules from full-duplex behaviour.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    localparam int WORD_W = 9;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } phase_t;

    typedef struct packed {
        logic nine;
        logic cpol;
        logic cpha;
        logic lastclk;
        logic hdx;
    } mode_t;
endpackage

// File: rtl/sstx_timer.sv
module sstx_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic [DIV_W-1:0] cnt_d,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_q;

    always_comb begin
        wrap = run && (cnt_q == period - DIV_W'(1));
        if (!run || wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sstx_sclk.sv
module sstx_sclk
    import sstx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase_d,
    input  logic [IDX_W-1:0] idx_d,
    input  logic [DIV_W-1:0] cnt_d,
    input  logic [DIV_W-1:0] half_d,
    input  mode_t            mode_d,
    output logic             sclk
);
    logic             sclk_d, sclk_q;
    logic             in_pulse;
    logic             pulse_ok;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        last_idx = mode_d.nine ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);
        in_pulse = mode_d.cpha ? (cnt_d < half_d) : (cnt_d >= half_d);
        pulse_ok = (phase_d == PH_DATA) && !mode_d.hdx &&
                   ((idx_d != last_idx) || mode_d.lastclk);
        sclk_d   = mode_d.cpol ^ (pulse_ok && in_pulse);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_d;
        end
    end

    assign sclk = sclk_q;
endmodule

// File: rtl/sstx_capture.sv
module sstx_capture
    import sstx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  phase_t            phase_d,
    input  logic [IDX_W-1:0]  idx_d,
    input  logic [DIV_W-1:0]  cnt_d,
    input  logic [DIV_W-1:0]  half_d,
    input  logic              line,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clear) begin
            word_d = '0;
        end else if (phase_d == PH_DATA && cnt_d == half_d) begin
            word_d[idx_d] = line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
    import sstx_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DIV_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              cfg_nine,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lastclk,
    input  logic              cfg_hdx,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              rx,
    output logic              tx,
    output logic              tx_oe,
    output logic              sclk,
    output logic              busy,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_done
);
    typedef struct packed {
        phase_t            phase;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
        mode_t             mode;
        logic [DIV_W-1:0]  div;
        logic              tx;
        logic              oe;
        logic              busy;
        logic              done;
    } state_t;

    state_t           st_d, st_q;
    logic             load;
    logic             bit_end;
    logic [DIV_W-1:0] cnt_d;
    logic [DIV_W-1:0] half_d;
    logic [IDX_W-1:0] last_q;
    logic             rx_line;

    sstx_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.phase != PH_IDLE),
        .period (st_q.div),
        .cnt_d  (cnt_d),
        .wrap   (bit_end)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = ld_valid && (st_q.phase == PH_IDLE);
        last_q    = st_q.mode.nine ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);

        if (st_q.phase == PH_IDLE) begin
            st_d.mode.nine    = cfg_nine;
            st_d.mode.cpol    = cfg_cpol;
            st_d.mode.cpha    = cfg_cpha;
            st_d.mode.lastclk = cfg_lastclk;
            st_d.mode.hdx     = cfg_hdx;
            st_d.div          = (cfg_div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : cfg_div;
        end

        if (load) begin
            st_d.phase = PH_START;
            st_d.idx   = '0;
            st_d.data  = cfg_nine ? ld_data : {1'b0, ld_data[WORD_W-2:0]};
        end else if (bit_end) begin
            case (st_q.phase)
                PH_START: begin
                    st_d.phase = PH_DATA;
                    st_d.idx   = '0;
                end
                PH_DATA: begin
                    if (st_q.idx == last_q) begin
                        st_d.phase = PH_STOP;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
                PH_STOP: begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = !st_q.mode.hdx;
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end

        case (st_d.phase)
            PH_START: st_d.tx = 1'b0;
            PH_DATA:  st_d.tx = st_d.data[st_d.idx];
            default:  st_d.tx = 1'b1;
        endcase
        st_d.busy = (st_d.phase != PH_IDLE);
        st_d.oe   = !st_d.mode.hdx || st_d.busy;
        half_d    = st_d.div >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.div   <= DIV_W'(DIV_MIN);
            st_q.tx    <= 1'b1;
            st_q.oe    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    sstx_sclk #(.DIV_W(DIV_W)) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (st_d.phase),
        .idx_d   (st_d.idx),
        .cnt_d   (cnt_d),
        .half_d  (half_d),
        .mode_d  (st_d.mode),
        .sclk    (sclk)
    );

    assign rx_line = st_q.mode.hdx ? st_q.tx : rx;

    sstx_capture #(.DIV_W(DIV_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .phase_d (st_d.phase),
        .idx_d   (st_d.idx),
        .cnt_d   (cnt_d),
        .half_d  (half_d),
        .line    (rx_line),
        .word    (rx_word)
    );

    assign tx      = st_q.tx;
    assign tx_oe   = st_q.oe;
    assign busy    = st_q.busy;
    assign rx_done = st_q.done;
endmodule

// File: rtl/sstx_checker.sv
module sstx_checker (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic cfg_cpol,
    input logic cfg_hdx,
    input logic tx,
    input logic tx_oe,
    input logic sclk,
    input logic busy,
    input logic rx_done
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $rose(busy) |-> $past(ld_valid));

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $rose(busy) |-> !tx);

    // R1
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $fell(busy) |-> tx);

    // R6
    done_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        rx_done |-> $fell(busy));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        rx_done |=> !rx_done);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (!busy && $past(!busy)) |-> (sclk == $past(cfg_cpol)));

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (!busy && $past(!busy)) |-> (tx_oe == !$past(cfg_hdx)));

    // R7
    oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        busy |-> tx_oe);
endmodule

bind sync_serial_tx sstx_checker chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .cfg_cpol (cfg_cpol),
    .cfg_hdx  (cfg_hdx),
    .tx       (tx),
    .tx_oe    (tx_oe),
    .sclk     (sclk),
    .busy     (busy),
    .rx_done  (rx_done)
);

// File: tb/sync_serial_tx_test.sv
module sync_serial_tx_test;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_valid = 1'b0;
    logic [8:0]       ld_data = '0;
    logic             cfg_nine = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic             cfg_lastclk = 1'b1, cfg_hdx = 1'b0;
    logic [DIV_W-1:0] cfg_div = 16'd8;
    logic             rx = 1'b1;
    logic             tx, tx_oe, sclk, busy, rx_done;
    logic [8:0]       rx_word;

    int total = 0;
    int bad = 0;

    typedef struct {
        string    tag;
        bit [8:0] data;
        bit [8:0] rxpat;
        bit       nine, cpol, cpha, lastclk, hdx, disturb;
        int       div;
    } item_t;

    item_t sb[$];

    sync_serial_tx #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
        .cfg_nine(cfg_nine), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lastclk(cfg_lastclk), .cfg_hdx(cfg_hdx), .cfg_div(cfg_div),
        .rx(rx), .tx(tx), .tx_oe(tx_oe), .sclk(sclk), .busy(busy),
        .rx_word(rx_word), .rx_done(rx_done)
    );

    always #10 clk = ~clk;

    task automatic check(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(item_t it);
        int d;
        d = (it.div < 4) ? 4 : it.div;
        sb.push_back(it);
        @(negedge clk);
        cfg_nine = it.nine; cfg_cpol = it.cpol; cfg_cpha = it.cpha;
        cfg_lastclk = it.lastclk; cfg_hdx = it.hdx; cfg_div = DIV_W'(it.div);
        ld_data = it.data; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        if (it.disturb) begin
            repeat (3 * d) @(negedge clk);
            cfg_cpol = ~cfg_cpol; cfg_cpha = ~cfg_cpha; cfg_nine = ~cfg_nine;
            cfg_lastclk = ~cfg_lastclk; cfg_div = DIV_W'(d + 6);
            ld_data = ~it.data; ld_valid = 1'b1;
            @(negedge clk);
            ld_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(it.disturb ? "R8 no second frame" : "R2 idle after frame", !busy, busy, 0);
    endtask

    // monitor: one scoreboard item per frame
    initial begin
        forever begin
            @(negedge clk);
            if (busy) begin
                item_t it;
                int d, h, n, len, etx, esc, eoe, ebusy;
                bit [8:0] dat, exw;
                string sreq;
                if (sb.size() == 0) begin
                    check("R2 unexpected frame", 1'b0, 1, 0);
                end else begin
                    it = sb.pop_front();
                    d = (it.div < 4) ? 4 : it.div;
                    h = d / 2;
                    n = it.nine ? 9 : 8;
                    len = (n + 2) * d;
                    dat = it.nine ? it.data : {1'b0, it.data[7:0]};
                    etx = 0; esc = 0; eoe = 0; ebusy = 0;
                    for (int k = 0; k < len; k++) begin
                        int b, c;
                        bit xt, act, xs;
                        if (k > 0) @(negedge clk);
                        b = k / d;
                        c = k % d;
                        if (b >= 1 && b <= n && c == 0) rx = it.rxpat[b-1];
                        if (b == 0) xt = 1'b0;
                        else if (b <= n) xt = dat[b-1];
                        else xt = 1'b1;
                        act = (b >= 1) && (b <= n) && !it.hdx && (b < n || it.lastclk) &&
                              (it.cpha ? (c < h) : (c >= h));
                        xs = it.cpol ^ act;
                        if (tx !== xt) etx++;
                        if (sclk !== xs) esc++;
                        if (tx_oe !== 1'b1) eoe++;
                        if (busy !== 1'b1) ebusy++;
                    end
                    @(negedge clk);
                    rx = 1'b1;
                    sreq = (it.div < 4) ? "R9" : (it.disturb ? "R8" : "R1");
                    check({sreq, " tx frame ", it.tag}, etx == 0, etx, 0);
                    sreq = it.hdx ? "R7" : (it.lastclk ? "R3" : "R4");
                    check({sreq, " R5 sclk pattern ", it.tag}, esc == 0, esc, 0);
                    check({"R7 tx_oe in frame ", it.tag}, eoe == 0, eoe, 0);
                    check({"R2 busy length ", it.tag}, ebusy == 0 && busy == 1'b0, ebusy, 0);
                    if (it.hdx) begin
                        check({"R7 no rx_done ", it.tag}, rx_done == 1'b0, rx_done, 0);
                    end else begin
                        exw = it.nine ? it.rxpat : {1'b0, it.rxpat[7:0]};
                        check({"R6 rx_done ", it.tag}, rx_done == 1'b1, rx_done, 1);
                        check({"R6 rx_word ", it.tag}, rx_word == exw, rx_word, exw);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1'b0, 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        // R10
        check("R10 tx", tx == 1'b1, tx, 1);
        check("R10 sclk", sclk == 1'b0, sclk, 0);
        check("R10 busy", busy == 1'b0, busy, 0);
        check("R10 rx_done", rx_done == 1'b0, rx_done, 0);
        check("R10 tx_oe", tx_oe == 1'b1, tx_oe, 1);
        check("R10 rx_word", rx_word == 9'h0, rx_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        it = '{tag:"m0", data:9'h0A5, rxpat:9'h03C, nine:0, cpol:0, cpha:0,
               lastclk:1, hdx:0, disturb:0, div:8};
        send(it);
        it = '{tag:"m3", data:9'h1A3, rxpat:9'h0F5, nine:1, cpol:1, cpha:1,
               lastclk:1, hdx:0, disturb:0, div:10};
        send(it);
        it = '{tag:"m1 nolast", data:9'h05A, rxpat:9'h0C3, nine:0, cpol:0, cpha:1,
               lastclk:0, hdx:0, disturb:0, div:6};
        send(it);
        it = '{tag:"m2 nolast", data:9'h155, rxpat:9'h1AA, nine:1, cpol:1, cpha:0,
               lastclk:0, hdx:0, disturb:0, div:12};
        send(it);
        it = '{tag:"bit8 ignored", data:9'h180, rxpat:9'h1FF, nine:0, cpol:0, cpha:0,
               lastclk:1, hdx:0, disturb:0, div:8};
        send(it);
        it = '{tag:"div clamp", data:9'h0C9, rxpat:9'h036, nine:0, cpol:1, cpha:1,
               lastclk:1, hdx:0, disturb:0, div:2};
        send(it);
        it = '{tag:"disturb", data:9'h0E1, rxpat:9'h01E, nine:0, cpol:0, cpha:0,
               lastclk:1, hdx:0, disturb:1, div:8};
        send(it);
        it = '{tag:"single wire", data:9'h12D, rxpat:9'h000, nine:1, cpol:1, cpha:0,
               lastclk:1, hdx:1, disturb:0, div:8};
        send(it);

        // R7 driver released while idle in single-wire mode
        check("R7 tx_oe idle hdx", tx_oe == 1'b0, tx_oe, 0);
        check("R5 idle level high", sclk == 1'b1, sclk, 1);
        cfg_hdx = 1'b0;
        cfg_cpol = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 tx_oe idle full duplex", tx_oe == 1'b1, tx_oe, 1);
        check("R5 idle level follows input", sclk == 1'b0, sclk, 0);
        check("R1 tx idle", tx == 1'b1, tx, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule